// File: doc/BRIEF.md
# Distributed Control/Status Register Bank

This block is a memory-mapped register bank made of many small, independent register slices. Every slice sits on one shared write bus. Each slice compares the address against its own index, and only a match qualified by the chip-select counts. A slice holds exactly one register, of one of three kinds:

- **Read/write storage**, which drives a control output.
- **Read-only status**, which shows a hardware input.
- **Sticky event latch**, which hardware sets and software clears by writing ones.

For readback, a selected slice presents its value and every other slice presents zero. The bank ORs all slice outputs together and registers the result, so there is no central address multiplexer and no internal high-impedance net. Adding or removing a slice means changing one generate entry. No central decoder has to be edited.

The default build has 100 slices of 32 bits. Slice `i` sits at word address `i`. Its kind is `i mod 3`: 0 is read/write, 1 is read-only, 2 is sticky. Within its kind, a slice uses group index `i / 3` to pick its lane of the flattened hardware vectors. With the default build that gives 34 read/write lanes, 33 status lanes and 33 event lanes.

Top module: `csr_bank`

## Requirements
- R1: A synchronous active-low reset loads every read/write slice with `32'hA500_0000 + i`, where `i` is the slice address. It clears every sticky slice to zero. It drives `bus_rvalid`, `bus_rdata`, `bus_dec_err` and `bus_multi_hit` to zero.
- R2: A read/write slice takes `bus_wdata` at the clock edge on which `bus_cs`, `bus_we` and an address match are all high. Its `ctrl_o` lane shows the new value from the following cycle.
- R3: A write with `bus_cs` low, or to a different address, leaves every read/write and sticky slice unchanged.
- R4: A read of a read-only slice returns the `hw_status_i` lane value present in the request cycle. Writes to a read-only slice have no effect on what it returns.
- R5: A one on any bit of a sticky slice's `hw_event_i` lane sets that bit, and the bit stays set until software clears it.
- R6: A write to a sticky slice clears exactly the bits where `bus_wdata` is 1. Bits written as 0 keep their value.
- R7: When a hardware event and a software clear hit the same sticky bit in the same cycle, the bit ends up set.
- R8: `bus_rvalid` is high exactly in the cycle after a cycle with `bus_cs` and `bus_re` both high. In that cycle `bus_rdata` carries the addressed value. In every other cycle `bus_rdata` is zero.
- R9: An access (read or write, with `bus_cs` high) to an address of `NUM_SLICES` or above returns zero read data. It raises `bus_dec_err` for exactly the following cycle.
- R10: At most one slice matches any address. `bus_multi_hit`, registered like `bus_dec_err`, stays low in the default configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Word address of the access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_cs | input | 1 | Chip-select qualifying all slice matches |
| bus_rdata | output | DATA_W (32) | Registered OR of all slice read outputs |
| bus_rvalid | output | 1 | Read data valid, one cycle after request |
| bus_dec_err | output | 1 | Previous access matched no slice |
| bus_multi_hit | output | 1 | Previous access matched more than one slice |
| hw_status_i | input | 33*DATA_W | Status lanes for read-only slices, by group index |
| hw_event_i | input | 33*DATA_W | Event-set lanes for sticky slices, by group index |
| ctrl_o | output | 34*DATA_W | Read/write slice contents, by group index |

## Verification
On every cycle, the embedded assertions check the following:
- At most one slice matches.
- Read-valid tracks a read request one cycle later, and read data is zero whenever it is not valid.
- Unmapped accesses raise the decode error.
- Read/write slices change only on their own write.
- A pulsed event bit is set in a sticky slice one cycle later.

Only the bench scenarios can show the data values themselves:
- Read/write reset values and written contents.
- Read-only lanes returning the live status input.
- Clearing by writing ones with partial masks.
- An event winning over a clear in the same cycle.
- The effect of writes without chip-select.

// File: rtl/csr_bank_pkg.sv
// Package: csr_bank_pkg
// Shared slice-kind encoding and address-map helpers for the register bank.
// Assumes slice i sits at word address i and its kind cycles with i mod 3.
package csr_bank_pkg;

    typedef enum logic [1:0] {
        KIND_RW     = 2'd0,
        KIND_RO     = 2'd1,
        KIND_STICKY = 2'd2
    } slice_kind_e;

    // Kind of the slice at a given address.
    function automatic slice_kind_e kind_of(input int idx);
        case (idx % 3)
            0:       return KIND_RW;
            1:       return KIND_RO;
            default: return KIND_STICKY;
        endcase
    endfunction

    // Number of slices of kind k among n slices.
    function automatic int kind_count(input int n, input int k);
        return (n - k + 2) / 3;
    endfunction

    // Lane index of a slice within its own kind.
    function automatic int group_of(input int idx);
        return idx / 3;
    endfunction

    // Reset value of a read/write slice.
    function automatic logic [31:0] rw_reset(input int idx);
        return 32'hA500_0000 + 32'(idx);
    endfunction

endpackage

// File: rtl/csr_slice_rw.sv
// Module: csr_slice_rw
// One read/write register. It decodes its own address under chip-select and
// loads on a write hit. It drives its value onto its read output only when
// read-selected, otherwise zero.
// Assumes: a single-cycle bus, synchronous active-low reset.
module csr_slice_rw #(
    parameter int              ADDR_W    = 8,
    parameter int              DATA_W    = 32,
    parameter int              INDEX     = 0,
    parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              match_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] value_o
);

    logic [DATA_W-1:0] value_q;
    logic              wr_hit;

    // Address match qualified by chip-select.
    assign match_o = cs && (addr == ADDR_W'(INDEX));
    assign wr_hit  = match_o && we;

    // Storage: reset value, or write data on a write hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= RESET_VAL;
        end else if (wr_hit) begin
            value_q <= wdata;
        end
    end

    // Read gating: zero unless this slice is read-selected.
    always_comb begin
        rdata_o = '0;
        if (match_o && re) begin
            rdata_o = value_q;
        end
    end

    assign value_o = value_q;

    assert_rw_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && we && addr == ADDR_W'(INDEX)) |=> (value_o == $past(wdata)));

    assert_rw_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && we && addr == ADDR_W'(INDEX)) |=> (value_o == $past(value_o)));

endmodule

// File: rtl/csr_slice_ro.sv
// Module: csr_slice_ro
// One read-only status register. It shows a hardware input while
// read-selected, otherwise zero. Writes are not connected at all.
// Assumes: the status input is synchronous to the bus clock.
module csr_slice_ro #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int INDEX  = 1
) (
    input  logic              cs,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] status_i,
    output logic              match_o,
    output logic [DATA_W-1:0] rdata_o
);

    // Address match qualified by chip-select.
    assign match_o = cs && (addr == ADDR_W'(INDEX));

    // Read gating of the live status value.
    always_comb begin
        rdata_o = '0;
        if (match_o && re) begin
            rdata_o = status_i;
        end
    end

endmodule

// File: rtl/csr_slice_sticky.sv
// Module: csr_slice_sticky
// One sticky event register. Hardware pulses set bits. A software write clears
// the bits written as one. An event beats a clear on the same bit.
// Assumes: event inputs are single-cycle, synchronous pulses.
module csr_slice_sticky #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int INDEX  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] event_i,
    output logic              match_o,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] flags_q;
    logic [DATA_W-1:0] clr_mask;

    // Address match qualified by chip-select.
    assign match_o  = cs && (addr == ADDR_W'(INDEX));
    assign clr_mask = (match_o && we) ? wdata : '0;

    // Flag update: clear by writing ones first, then OR in the events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_mask) | event_i;
        end
    end

    // Read gating: zero unless this slice is read-selected.
    always_comb begin
        rdata_o = '0;
        if (match_o && re) begin
            rdata_o = flags_q;
        end
    end

    assert_sticky_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|event_i) |=> ((flags_q & $past(event_i)) == $past(event_i)));

    assert_sticky_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && we && addr == ADDR_W'(INDEX)) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

endmodule

// File: rtl/csr_or_reduce.sv
// Module: csr_or_reduce
// Combines all slice read outputs with a bitwise OR. It also reports whether
// any slice, or more than one slice, claimed the current address.
// Assumes: every unselected slice presents all-zero read data.
module csr_or_reduce #(
    parameter int NUM    = 100,
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] rd_i [NUM],
    input  logic [NUM-1:0]    match_i,
    output logic [DATA_W-1:0] rd_o,
    output logic              any_o,
    output logic              multi_o
);

    // OR tree over all slice read outputs.
    always_comb begin
        rd_o = '0;
        for (int i = 0; i < NUM; i++) begin
            rd_o = rd_o | rd_i[i];
        end
    end

    // Hit detection: flags a second match seen after a first.
    always_comb begin
        logic seen;
        seen    = 1'b0;
        multi_o = 1'b0;
        for (int i = 0; i < NUM; i++) begin
            if (match_i[i]) begin
                if (seen) multi_o = 1'b1;
                seen = 1'b1;
            end
        end
        any_o = seen;
    end

endmodule

// File: rtl/csr_bank.sv
// Module: csr_bank
// Top of the distributed register bank. It instantiates one slice per address
// in a generate loop, ORs their gated read outputs and registers the read
// response and the decode flags.
// Assumes: ADDR_W can hold every slice address, and at least three slices.
module csr_bank
    import csr_bank_pkg::*;
#(
    parameter int NUM_SLICES = 100,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 8,
    localparam int N_RW      = kind_count(NUM_SLICES, 0),
    localparam int N_RO      = kind_count(NUM_SLICES, 1),
    localparam int N_ST      = kind_count(NUM_SLICES, 2)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    input  logic                   bus_we,
    input  logic                   bus_re,
    input  logic                   bus_cs,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic                   bus_rvalid,
    output logic                   bus_dec_err,
    output logic                   bus_multi_hit,
    input  logic [N_RO*DATA_W-1:0] hw_status_i,
    input  logic [N_ST*DATA_W-1:0] hw_event_i,
    output logic [N_RW*DATA_W-1:0] ctrl_o
);

    logic [DATA_W-1:0]     slice_rd [NUM_SLICES];
    logic [NUM_SLICES-1:0] slice_match;
    logic [DATA_W-1:0]     or_rd;
    logic                  any_hit;
    logic                  multi_hit;
    logic                  access;

    // One slice per address, kind chosen by the address map.
    for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
        localparam int GRP = group_of(i);
        if (kind_of(i) == KIND_RW) begin : g_rw
            csr_slice_rw #(
                .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX(i),
                .RESET_VAL(DATA_W'(rw_reset(i)))
            ) u_slice (
                .clk(clk), .rst_n(rst_n), .cs(bus_cs), .we(bus_we), .re(bus_re),
                .addr(bus_addr), .wdata(bus_wdata),
                .match_o(slice_match[i]), .rdata_o(slice_rd[i]),
                .value_o(ctrl_o[GRP*DATA_W +: DATA_W])
            );
        end else if (kind_of(i) == KIND_RO) begin : g_ro
            csr_slice_ro #(
                .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX(i)
            ) u_slice (
                .cs(bus_cs), .re(bus_re), .addr(bus_addr),
                .status_i(hw_status_i[GRP*DATA_W +: DATA_W]),
                .match_o(slice_match[i]), .rdata_o(slice_rd[i])
            );
        end else begin : g_st
            csr_slice_sticky #(
                .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX(i)
            ) u_slice (
                .clk(clk), .rst_n(rst_n), .cs(bus_cs), .we(bus_we), .re(bus_re),
                .addr(bus_addr), .wdata(bus_wdata),
                .event_i(hw_event_i[GRP*DATA_W +: DATA_W]),
                .match_o(slice_match[i]), .rdata_o(slice_rd[i])
            );
        end
    end

    // Readback combine and hit detection.
    csr_or_reduce #(.NUM(NUM_SLICES), .DATA_W(DATA_W)) u_reduce (
        .rd_i(slice_rd), .match_i(slice_match),
        .rd_o(or_rd), .any_o(any_hit), .multi_o(multi_hit)
    );

    assign access = bus_cs && (bus_re || bus_we);

    // Response register: read data, valid strobe and decode flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata     <= '0;
            bus_rvalid    <= 1'b0;
            bus_dec_err   <= 1'b0;
            bus_multi_hit <= 1'b0;
        end else begin
            bus_rvalid    <= bus_cs && bus_re;
            bus_rdata     <= (bus_cs && bus_re) ? or_rd : '0;
            bus_dec_err   <= access && !any_hit;
            bus_multi_hit <= access && multi_hit;
        end
    end

    assert_single_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slice_match));

    assert_rvalid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && bus_re) |=> bus_rvalid);

    assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_cs && bus_re) |=> !bus_rvalid);

    assert_idle_rdata_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rvalid |-> (bus_rdata == '0));

    assert_unmapped_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (access && bus_addr >= ADDR_W'(NUM_SLICES)) |=> (bus_dec_err && bus_rdata == '0));

endmodule

// File: tb/csr_bank_test.sv
module csr_bank_test;

    localparam int N    = 100;
    localparam int DW   = 32;
    localparam int AW   = 8;
    localparam int NRW  = 34;
    localparam int NRO  = 33;
    localparam int NST  = 33;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [DW-1:0]     bus_wdata = '0;
    logic              bus_we = 1'b0, bus_re = 1'b0, bus_cs = 1'b0;
    logic [DW-1:0]     bus_rdata;
    logic              bus_rvalid, bus_dec_err, bus_multi_hit;
    logic [NRO*DW-1:0] hw_status = '0;
    logic [NST*DW-1:0] hw_event = '0;
    logic [NRW*DW-1:0] ctrl_o;

    always #2.5 clk = ~clk;

    csr_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_cs(bus_cs),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .bus_dec_err(bus_dec_err), .bus_multi_hit(bus_multi_hit),
        .hw_status_i(hw_status), .hw_event_i(hw_event), .ctrl_o(ctrl_o)
    );

    int checks = 0;
    int failures = 0;
    bit chk_on = 0;
    bit done = 0;
    string cur_req = "R1";

    // Behavioural reference model
    logic [DW-1:0] rw_m [NRW];
    logic [DW-1:0] st_m [NST];
    logic [DW-1:0] exp_rdata = '0;
    logic          exp_rvalid = 0, exp_err = 0;

    task automatic check(input string req, input string what, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s got=%h exp=%h t=%0t", req, what, got, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NRW; i++) rw_m[i] = 32'hA500_0000 + 32'(3*i);
            for (int i = 0; i < NST; i++) st_m[i] = '0;
            exp_rdata = '0; exp_rvalid = 0; exp_err = 0;
        end else begin
            int a;
            a = int'(bus_addr);
            exp_rvalid = bus_cs && bus_re;
            exp_rdata  = '0;
            if (exp_rvalid && a < N) begin
                if (a % 3 == 0)      exp_rdata = rw_m[a/3];
                else if (a % 3 == 1) exp_rdata = hw_status[(a/3)*DW +: DW];
                else                 exp_rdata = st_m[a/3];
            end
            exp_err = bus_cs && (bus_re || bus_we) && (a >= N);
            for (int g = 0; g < NST; g++) begin
                logic [DW-1:0] clr;
                clr = (bus_cs && bus_we && a == 3*g + 2) ? bus_wdata : '0;
                st_m[g] = (st_m[g] & ~clr) | hw_event[g*DW +: DW];
            end
            if (bus_cs && bus_we && a < N && a % 3 == 0) rw_m[a/3] = bus_wdata;
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (chk_on) begin
            check(cur_req, "rvalid", 32'(bus_rvalid), 32'(exp_rvalid));
            check(cur_req, "rdata", bus_rdata, exp_rdata);
            check(cur_req, "dec_err", 32'(bus_dec_err), 32'(exp_err));
            check("R10", "multi_hit", 32'(bus_multi_hit), 32'd0);
            for (int g = 0; g < NRW; g++)
                check(cur_req, "ctrl_o", ctrl_o[g*DW +: DW], rw_m[g]);
        end
    end

    task automatic cyc(input bit cs, input bit we, input bit re, input int addr,
                       input logic [DW-1:0] wd, input int ev_grp, input logic [DW-1:0] ev_bits);
        @(negedge clk);
        bus_cs = cs; bus_we = we; bus_re = re; bus_addr = AW'(addr); bus_wdata = wd;
        hw_event = '0;
        if (ev_grp >= 0) hw_event[ev_grp*DW +: DW] = ev_bits;
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, '0, -1, '0);
    endtask

    // Read, then sample the response at the next negedge
    task automatic read_expect(input string req, input int addr, input logic [DW-1:0] exp);
        cyc(1, 0, 1, addr, '0, -1, '0);
        idle();
        check(req, "directed rdata", bus_rdata, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired got=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1;
        // R1: reset values
        cur_req = "R1";
        check("R1", "rvalid after reset", 32'(bus_rvalid), 32'd0);
        check("R1", "ctrl lane 0", ctrl_o[0 +: DW], 32'hA500_0000);
        check("R1", "ctrl lane 33", ctrl_o[33*DW +: DW], 32'hA500_0063);
        read_expect("R1", 2, 32'h0);
        read_expect("R1", 99, 32'hA500_0063);

        // R2: writes to read/write slices
        cur_req = "R2";
        cyc(1, 1, 0, 0, 32'h1234_5678, -1, '0);
        cyc(1, 1, 0, 51, 32'hDEAD_BEEF, -1, '0);
        idle();
        check("R2", "ctrl lane 17", ctrl_o[17*DW +: DW], 32'hDEAD_BEEF);
        read_expect("R2", 0, 32'h1234_5678);

        // R3: write without chip-select or to other address
        cur_req = "R3";
        cyc(0, 1, 0, 3, 32'hFFFF_FFFF, -1, '0);
        cyc(1, 1, 0, 4, 32'h5555_5555, -1, '0);
        idle();
        read_expect("R3", 3, 32'hA500_0003);

        // R4: read-only status
        cur_req = "R4";
        hw_status[0 +: DW] = 32'hCAFE_0001;
        hw_status[32*DW +: DW] = 32'h0BAD_F00D;
        read_expect("R4", 1, 32'hCAFE_0001);
        cyc(1, 1, 0, 97, 32'h0, -1, '0);
        read_expect("R4", 97, 32'h0BAD_F00D);

        // R5: sticky set and hold
        cur_req = "R5";
        cyc(0, 0, 0, 0, '0, 0, 32'h0000_0011);
        idle(); idle();
        read_expect("R5", 2, 32'h0000_0011);
        cyc(0, 0, 0, 0, '0, 0, 32'h0000_0100);
        idle();
        read_expect("R5", 2, 32'h0000_0111);

        // R6: write ones to clear, partial mask
        cur_req = "R6";
        cyc(1, 1, 0, 2, 32'h0000_0101, -1, '0);
        read_expect("R6", 2, 32'h0000_0010);

        // R7: event beats clear on the same bit
        cur_req = "R7";
        cyc(1, 1, 0, 2, 32'h0000_0010, 0, 32'h0000_0010);
        read_expect("R7", 2, 32'h0000_0010);

        // R8: back-to-back reads and reads without chip-select
        cur_req = "R8";
        cyc(1, 0, 1, 0, '0, -1, '0);
        cyc(1, 0, 1, 99, '0, -1, '0);
        cyc(0, 0, 1, 0, '0, -1, '0);
        idle();

        // R9: unmapped addresses
        cur_req = "R9";
        cyc(1, 0, 1, 100, '0, -1, '0);
        idle();
        check("R9", "dec_err", 32'(bus_dec_err), 32'd1);
        check("R9", "rdata unmapped", bus_rdata, 32'd0);
        cyc(1, 1, 0, 200, 32'hFFFF_FFFF, -1, '0);
        cyc(1, 0, 1, 255, '0, -1, '0);
        idle(); idle();

        // R10: sweep every address, then random traffic
        cur_req = "R10";
        for (int a = 0; a < N; a++) cyc(1, 0, 1, a, '0, -1, '0);
        for (int k = 0; k < 3000; k++) begin
            hw_status[($urandom % NRO)*DW +: DW] = $urandom;
            cyc($urandom % 4 != 0, $urandom % 3 == 0, $urandom % 2 == 0,
                ($urandom % 8 == 0) ? 100 + $urandom % 156 : $urandom % N,
                $urandom, ($urandom % 4 == 0) ? int'($urandom % NST) : -1, $urandom & $urandom);
        end
        idle(); idle();
        finish_run();
    end

endmodule